// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block lets software reach the management registers of external Ethernet PHYs over a two-wire MDIO bus using Clause 22 frames. Software starts a transfer by writing one packed command word. That word holds a start flag, the operation, the PHY address, the register address and, for a write, the 16-bit value. The block then produces the management clock MDC from the system clock and shifts the frame out MSB first. For a read, it releases the data line at the turnaround and shifts the PHY's answer in.

Software polls a busy flag in the status register until the frame has finished. Read results come back in a data register, with a two-bit error field next to the 16-bit value. The error field is set when no PHY pulls the line low in the second turnaround bit. A write is fire-and-forget: software only needs to check the busy flag before it issues its next command.

The register port is a plain 32-bit bus with address, write enable, write data and a combinational read-data output. MDIO is split into an output, an output enable and an input, so the tri-state buffer can sit at the pad.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, the status word, the data word, `mdc` and `mdio_oe` all read 0.
- R2: A write to offset 0x8 is accepted when all of the following hold: bit 31 is 1, bits 2:1 are 01 (write) or 10 (read), and the block is idle. After acceptance, status bit 3 (busy) reads 1 from the next cycle for exactly 128*DIV_HALF cycles.
- R3: Each frame is 64 bits sent MSB first, in this order: 32 ones, start bits 01, opcode (10 for read, 01 for write), PHY address from command bits 29:25, register address from bits 24:20, and 16 data bits. For a write, the frame also carries turnaround 10, and the data bits come from command bits 19:4.
- R4: MDC is low while the block is idle. During a frame MDC has a period of 2*DIV_HALF system cycles and gives exactly 64 rising edges. The MDIO output changes only when MDC falls.
- R5: In a read, `mdio_oe` is low from the first turnaround bit (bit 46) to the end of the frame. The 16 bits sampled on the MDC rising edges of bits 48..63 appear MSB first in data-register bits 15:0 once busy clears.
- R6: After a read, data-register bits 17:16 are 11 if `mdio_i` was high at the rising edge of the second turnaround bit, and 00 otherwise. Bits 31:18 read 0.
- R7: A command is ignored, with no frame started and no register changed, if any of these is true: bit 31 is clear, bits 2:1 are 00 or 11, or the block is busy. A command written while busy leaves the running frame unchanged.
- R8: A write frame leaves the data register unchanged.
- R9: Status bits other than bit 3 read 0, and reads of offsets other than 0x0 and 0xC return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
The embedded assertions check, on every cycle, these properties:
- an accepted command raises busy on the next cycle;
- MDC and the output enable stay low while idle;
- the MDIO output moves only on falling MDC;
- the line stays released through the read turnaround and data phase;
- the operation latched for a running frame does not change;
- the error field is always 00 or 11.

The bench's scenarios, which use a PHY model on the wires, are what show the rest. They show the exact bit content of each frame, the busy length of 128*DIV_HALF cycles, and the read value with its error flags for both a responding and a silent PHY. They also show that rejected commands leave the bus quiet and the data register untouched.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_LEN  = 64;
  localparam int TA_FIRST   = 46;
  localparam int TA_LAST    = 47;
  localparam int DATA_FIRST = 48;

  localparam int OFF_STATUS = 'h0;
  localparam int OFF_CMD    = 'h8;
  localparam int OFF_DATA   = 'hC;

  localparam int BUSY_BIT  = 3;
  localparam int VALID_BIT = 31;
  localparam int OPW_BIT   = 1;
  localparam int OPR_BIT   = 2;
  localparam int WD_LSB    = 4;
  localparam int REG_LSB   = 20;
  localparam int PHY_LSB   = 25;
  localparam int ERR_LSB   = 16;

  typedef struct packed {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdata;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              rd_done,
  input  logic [15:0]       rd_value,
  input  logic              rd_fail,
  output logic              start,
  output mdio_cmd_t         cmd
);
  logic [31:0] data_q;
  logic        op_ok;
  logic        hit_cmd;

  assign op_ok   = reg_wdata[OPW_BIT] ^ reg_wdata[OPR_BIT];
  assign hit_cmd = reg_wr_en && (reg_addr == ADDR_W'(OFF_CMD));
  assign start   = hit_cmd && reg_wdata[VALID_BIT] && op_ok && !busy;

  assign cmd.rd    = reg_wdata[OPR_BIT];
  assign cmd.phy   = reg_wdata[PHY_LSB +: 5];
  assign cmd.regad = reg_wdata[REG_LSB +: 5];
  assign cmd.wdata = reg_wdata[WD_LSB +: 16];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (rd_done) begin
      data_q <= {14'b0, {2{rd_fail}}, rd_value};
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(OFF_STATUS)) begin
      reg_rdata[BUSY_BIT] = busy;
    end else if (reg_addr == ADDR_W'(OFF_DATA)) begin
      reg_rdata = data_q;
    end
  end

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R6
  err_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_q[ERR_LSB] == data_q[ERR_LSB+1]);

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |=> $stable(data_q));
endmodule

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt;
  logic          mdc_q;
  logic          wrap;

  assign wrap = (cnt == CW'(DIV_HALF - 1));
  assign rise = run && wrap && !mdc_q;
  assign fall = run && wrap && mdc_q;
  assign mdc  = mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4
  mdc_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> (!run || $stable(mdc_q)));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mdio_cmd_t   cmd,
  input  logic        rise,
  input  logic        fall,
  input  logic        mdc,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        rd_done,
  output logic [15:0] rd_value,
  output logic        rd_fail
);
  localparam int IW = $clog2(FRAME_LEN);

  logic [FRAME_LEN-1:0] shreg;
  logic [IW-1:0]        bit_idx;
  logic [IW-1:0]        nxt_idx;
  logic                 busy_q;
  logic                 rd_q;
  logic                 ta_bad;
  logic [15:0]          rx_q;
  logic                 last_bit;
  logic [FRAME_LEN-1:0] frame;

  assign frame = {32'hFFFF_FFFF, 2'b01,
                  cmd.rd ? 2'b10 : 2'b01,
                  cmd.phy, cmd.regad,
                  cmd.rd ? 2'b11 : 2'b10,
                  cmd.rd ? 16'hFFFF : cmd.wdata};

  assign nxt_idx  = bit_idx + 1'b1;
  assign last_bit = (bit_idx == IW'(FRAME_LEN - 1));
  assign busy     = busy_q;
  assign rd_done  = busy_q && rd_q && fall && last_bit;
  assign rd_value = rx_q;
  assign rd_fail  = ta_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      shreg   <= '0;
      bit_idx <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      ta_bad  <= 1'b0;
      rx_q    <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q  <= 1'b1;
        rd_q    <= cmd.rd;
        shreg   <= frame;
        bit_idx <= '0;
        mdio_o  <= frame[FRAME_LEN-1];
        mdio_oe <= 1'b1;
        ta_bad  <= 1'b0;
        rx_q    <= '0;
      end
    end else if (rise) begin
      if (rd_q && bit_idx == IW'(TA_LAST)) begin
        ta_bad <= mdio_i;
      end
      if (rd_q && bit_idx >= IW'(DATA_FIRST)) begin
        rx_q <= {rx_q[14:0], mdio_i};
      end
    end else if (fall) begin
      if (last_bit) begin
        busy_q  <= 1'b0;
        mdio_oe <= 1'b0;
        mdio_o  <= 1'b0;
      end else begin
        bit_idx <= nxt_idx;
        shreg   <= {shreg[FRAME_LEN-2:0], 1'b0};
        mdio_o  <= shreg[FRAME_LEN-2];
        mdio_oe <= !(rd_q && nxt_idx >= IW'(TA_FIRST));
      end
    end
  end

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!mdc && !mdio_oe));

  // R4
  out_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$fell(mdc)) |-> $stable(mdio_o));

  // R5
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rd_q && bit_idx >= IW'(TA_FIRST)) |-> !mdio_oe);

  // R7
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(rd_q));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DIV_HALF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic        busy;
  logic        start;
  mdio_cmd_t   cmd;
  logic        rise;
  logic        fall;
  logic        rd_done;
  logic [15:0] rd_value;
  logic        rd_fail;

  mdio_mgmt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .busy(busy), .rd_done(rd_done), .rd_value(rd_value), .rd_fail(rd_fail),
    .start(start), .cmd(cmd)
  );

  mdio_mdc_div #(.DIV_HALF(DIV_HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n),
    .start(start), .cmd(cmd), .rise(rise), .fall(fall), .mdc(mdc),
    .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_done(rd_done), .rd_value(rd_value), .rd_fail(rd_fail)
  );
endmodule

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;
  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int          ph_cnt = 0;
  logic [63:0] cap, capoe;
  logic        phy_resp = 1'b1;
  logic [15:0] phy_val = '0;
  logic [31:0] exp_data = '0;

  always #5 clk = ~clk;

  mdio_mgmt_master #(.ADDR_W(4), .DIV_HALF(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model: records wire bits on MDC rise, answers after MDC fall
  always @(posedge mdc) begin
    if (ph_cnt < 64) begin
      cap[63-ph_cnt]   = mdio_o;
      capoe[63-ph_cnt] = mdio_oe;
    end
    ph_cnt = ph_cnt + 1;
  end

  always @(negedge mdc) begin
    if (phy_resp && ph_cnt == 47) mdio_i = 1'b0;
    else if (phy_resp && ph_cnt >= 48 && ph_cnt <= 63) mdio_i = phy_val[63-ph_cnt];
    else mdio_i = 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] build_frame(input logic rd, input logic [4:0] phy,
      input logic [4:0] ra, input logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, ra,
            rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : wd};
  endfunction

  function automatic logic [63:0] oe_mask(input logic rd);
    return rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : 64'hFFFF_FFFF_FFFF_FFFF;
  endfunction

  function automatic logic [31:0] cmd_word(input logic rd, input logic [4:0] phy,
      input logic [4:0] ra, input logic [15:0] wd);
    return {1'b1, 1'b0, phy, ra, wd, 1'b0, rd, !rd, 1'b0};
  endfunction

  task automatic write_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_addr = 4'h0;
    #1;
  endtask

  task automatic read_reg(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata; reg_addr = 4'h0; #1;
  endtask

  task automatic run_cmd(input logic rd, input logic [4:0] phy, input logic [4:0] ra,
      input logic [15:0] wd, input logic resp, input logic [15:0] rv, input bit mid);
    logic [63:0] fr, mk;
    logic [31:0] d;
    int n;
    phy_resp = resp; phy_val = rv; ph_cnt = 0; cap = '0; capoe = '0;
    write_reg(4'h8, cmd_word(rd, phy, ra, wd));
    check(reg_rdata[3] === 1'b1, "R2 busy after accept", 64'(reg_rdata), 64'h8);
    n = 0;
    while (reg_rdata[3]) begin
      n++;
      if (mid && n == 20) begin
        reg_addr = 4'h8; reg_wr_en = 1'b1;
        reg_wdata = cmd_word(!rd, ~phy, ~ra, ~wd);
      end
      @(negedge clk);
      reg_wr_en = 1'b0; reg_addr = 4'h0; #1;
    end
    check(n == 128*DIV, "R2 busy length", 64'(n), 64'(128*DIV));
    check(ph_cnt == 64, "R4 MDC rising edges", 64'(ph_cnt), 64'd64);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R4 idle after frame", {62'b0, mdc, mdio_oe}, 64'd0);
    fr = build_frame(rd, phy, ra, wd);
    mk = oe_mask(rd);
    check((cap & mk) == (fr & mk), mid ? "R7 frame kept under busy write" : "R3 frame bits", cap & mk, fr & mk);
    check(capoe == mk, "R5 output enable pattern", capoe, mk);
    if (rd) exp_data = resp ? {16'h0, rv} : 32'h0003_FFFF;
    read_reg(4'hC, d);
    check(d == exp_data, rd ? (resp ? "R5 read data" : "R6 no-response flags") : "R8 write keeps data",
          64'(d), 64'(exp_data));
  endtask

  task automatic try_ignored(input logic [31:0] w, input string tag);
    logic [31:0] d;
    ph_cnt = 0;
    write_reg(4'h8, w);
    check(reg_rdata[3] == 1'b0 && !mdio_oe, tag, 64'(reg_rdata), 64'd0);
    repeat (4*DIV) @(negedge clk);
    check(ph_cnt == 0, tag, 64'(ph_cnt), 64'd0);
    read_reg(4'hC, d);
    check(d == exp_data, tag, 64'(d), 64'(exp_data));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    read_reg(4'h0, d); check(d == 0, "R1 status after reset", 64'(d), 0);
    read_reg(4'hC, d); check(d == 0, "R1 data after reset", 64'(d), 0);
    check(mdc == 0 && mdio_oe == 0, "R1 wires after reset", {62'b0, mdc, mdio_oe}, 0);
    // R9 unused offsets
    read_reg(4'h4, d); check(d == 0, "R9 offset 0x4", 64'(d), 0);
    read_reg(4'h8, d); check(d == 0, "R9 offset 0x8", 64'(d), 0);

    // directed corner cases
    run_cmd(1'b1, 5'h1F, 5'h00, 16'h0, 1'b1, 16'h8001, 0);
    run_cmd(1'b1, 5'h03, 5'h1F, 16'h0, 1'b0, 16'h0, 0);
    run_cmd(1'b0, 5'h00, 5'h15, 16'hA5C3, 1'b1, 16'h0, 0);
    run_cmd(1'b1, 5'h0A, 5'h02, 16'h0, 1'b1, 16'h0000, 0);
    run_cmd(1'b0, 5'h11, 5'h07, 16'hFFFF, 1'b1, 16'h0, 1);
    run_cmd(1'b1, 5'h05, 5'h09, 16'h0, 1'b1, 16'h1234, 1);
    // R7 rejected command words
    try_ignored(cmd_word(1'b1, 5'h2, 5'h3, 16'h0) & 32'h7FFF_FFFF, "R7 valid clear");
    try_ignored(cmd_word(1'b1, 5'h2, 5'h3, 16'h0) & ~32'h6, "R7 opcode 00");
    try_ignored(cmd_word(1'b1, 5'h2, 5'h3, 16'h0) | 32'h6, "R7 opcode 11");
    read_reg(4'h0, d); check(d == 0, "R9 status idle bits", 64'(d), 0);

    // constrained random transfers
    for (int i = 0; i < 30; i++) begin
      logic rd, resp;
      rd   = 1'($urandom);
      resp = ($urandom % 5) != 0;
      run_cmd(rd, 5'($urandom), 5'($urandom), 16'($urandom), resp, 16'($urandom), 0);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule